// File: doc/BRIEF.md
# Switch Byte Hex Viewer

This block drives a four-digit, time-multiplexed seven-segment display and a row of eight LEDs from one fast clock. It takes an 8-bit value from slide switches and displays it in hexadecimal twice. The left pair of digits shows the byte as read, and the right pair shows its bitwise inverse. Only one digit is driven at a time. A prescaler steps a small scan counter. A decoder turns that counter into one active-low anode enable, and a multiplexer places the matching active-low cathode pattern on the shared segment lines.

A second prescaler moves a single lit LED along the row, wrapping from the top LED back to the bottom. Five control outputs for memories on the board that go unused are held at their inactive level, so those parts stay off the shared bus. Reset is asynchronous and active low. It is released synchronously through a two-flop synchronizer, and it returns the LED to position 0 and the scan to digit 0.

Top module: `hexview_top`

## Requirements
- R1: The five memory control outputs `ram_ce_n`, `flash_ce_n`, `flash_rst_n`, `mem_we_n` and `mem_oe_n` are 1 at all times.
- R2: Out of reset, exactly one bit of `an_n` is 0. Digit i is selected when `an_n[i]` is 0.
- R3: `seg_n[6:0]` carries segments g..a (bit 0 = a, bit 6 = g), active low. It shows the selected digit's nibble as the usual hex glyph (0-9, A, b, C, d, E, F).
- R4: `seg_n[7]`, the decimal point, is always 1 (point dark).
- R5: Digit 3 shows `sw[7:4]`, digit 2 shows `sw[3:0]`, digit 1 shows `~sw[7:4]` and digit 0 shows `~sw[3:0]`.
- R6: The selected digit advances exactly once every `SCAN_DIV` clocks, in the order 0,1,2,3,0.
- R7: Exactly one bit of `led` is 1. It moves up one position every `WALK_DIV` clocks, and bit 7 wraps to bit 0.
- R8: While `rst_n` is low, the block selects digit 0 (`an_n` = 1110) and lights `led[0]` (`led` = 0x01), without waiting for a clock edge.
- R9: A change on `sw` reaches `seg_n` in the same cycle, without waiting for the next scan step.
- R10: When both prescalers restart together after reset and `WALK_DIV` is a multiple of `SCAN_DIV`, every LED step falls in a cycle where the digit also steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz on the board) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sw | input | 8 | Switch byte, up = 1 |
| led | output | 8 | Walking one-hot LED pattern |
| an_n | output | 4 | Active-low digit anode enables |
| seg_n | output | 8 | Active-low cathodes: bit 7 point, bits 6..0 segments g..a |
| ram_ce_n | output | 1 | RAM chip enable, held inactive |
| flash_ce_n | output | 1 | Flash chip enable, held inactive |
| flash_rst_n | output | 1 | Flash reset, held inactive |
| mem_we_n | output | 1 | Shared memory write enable, held inactive |
| mem_oe_n | output | 1 | Shared memory output enable, held inactive |

## Verification
The scan step and the LED step are driven by separate prescalers. Both restart on reset release, so with a walk period that is a whole multiple of the scan period, the two must land on the same clock edge. The bench uses scan and walk periods in a 1:4 ratio. On every cycle in which the LED moves, it checks that the anode selection moved in that same cycle, and it checks the period of each step on its own. A switch change made in the middle of a scan period is checked for immediate effect on the cathodes. This checks that the display multiplexer does not hold a stale value while the scan counter is still.

// File: rtl/hexview_pkg.sv
package hexview_pkg;

  localparam int NIB_W = 4;
  localparam int CATH_W = 8;

  typedef logic [CATH_W-1:0] cath_t;

  // Active-low cathode word for one hex nibble; bit 7 is the point (kept dark).
  function automatic cath_t hex_glyph(input logic [NIB_W-1:0] nib);
    logic [6:0] on;
    unique case (nib)
      4'h0: on = 7'h3F;
      4'h1: on = 7'h06;
      4'h2: on = 7'h5B;
      4'h3: on = 7'h4F;
      4'h4: on = 7'h66;
      4'h5: on = 7'h6D;
      4'h6: on = 7'h7D;
      4'h7: on = 7'h07;
      4'h8: on = 7'h7F;
      4'h9: on = 7'h6F;
      4'hA: on = 7'h77;
      4'hB: on = 7'h7C;
      4'hC: on = 7'h39;
      4'hD: on = 7'h5E;
      4'hE: on = 7'h79;
      default: on = 7'h71;
    endcase
    return {1'b1, ~on};
  endfunction

endpackage

// File: rtl/hexview_tick.sv
module hexview_tick #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6

endmodule

// File: rtl/hexview_scan.sv
module hexview_scan
  import hexview_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [DATA_W-1:0]   sw,
  output logic [2*DATA_W/NIB_W-1:0] an_n,
  output cath_t               seg_n
);

  localparam int DIGITS = 2 * DATA_W / NIB_W;
  localparam int SCW    = (DIGITS > 2) ? $clog2(DIGITS) : 1;
  localparam logic [SCW-1:0] LAST = SCW'(DIGITS - 1);

  logic [SCW-1:0] scan_q, scan_d;
  logic [2*DATA_W-1:0] word;
  cath_t cath [DIGITS];

  // True byte on the upper digits, complement on the lower ones.
  assign word = {sw, ~sw};

  always_comb begin
    scan_d = scan_q;
    if (step) scan_d = (scan_q == LAST) ? '0 : scan_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_q <= '0;
    else        scan_q <= scan_d;
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign cath[g] = hex_glyph(word[g*NIB_W +: NIB_W]);
    assign an_n[g] = (scan_q != SCW'(g));
  end

  assign seg_n = cath[scan_q];

  AST_AN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(~an_n)); // R2
  AST_DP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    seg_n[CATH_W-1]); // R4
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(an_n)); // R6

endmodule

// File: rtl/hexview_walk.sv
module hexview_walk #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [N-1:0] led
);

  logic [N-1:0] led_q, led_d;

  always_comb begin
    led_d = led_q;
    if (step) led_d = {led_q[N-2:0], led_q[N-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= N'(1);
    else        led_q <= led_d;
  end

  assign led = led_q;

  AST_LED_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(led)); // R7
  AST_LED_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (led[N-1] && step) |=> led[0]); // R7

endmodule

// File: rtl/hexview_top.sv
module hexview_top
  import hexview_pkg::*;
#(
  parameter int SCAN_DIV = 50000,
  parameter int WALK_DIV = 12500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sw,
  output logic [7:0] led,
  output logic [3:0] an_n,
  output logic [7:0] seg_n,
  output logic       ram_ce_n,
  output logic       flash_ce_n,
  output logic       flash_rst_n,
  output logic       mem_we_n,
  output logic       mem_oe_n
);

  logic [1:0] sync_q;
  logic       rst_sync_n;
  logic       scan_step, walk_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  hexview_tick #(.DIV(SCAN_DIV)) u_scan_tick (
    .clk(clk), .rst_n(rst_sync_n), .tick(scan_step));

  hexview_tick #(.DIV(WALK_DIV)) u_walk_tick (
    .clk(clk), .rst_n(rst_sync_n), .tick(walk_step));

  hexview_scan #(.DATA_W(8)) u_scan (
    .clk(clk), .rst_n(rst_sync_n), .step(scan_step),
    .sw(sw), .an_n(an_n), .seg_n(seg_n));

  hexview_walk #(.N(8)) u_walk (
    .clk(clk), .rst_n(rst_sync_n), .step(walk_step), .led(led));

  // Unused memories parked: every control at its inactive level.
  assign ram_ce_n    = 1'b1;
  assign flash_ce_n  = 1'b1;
  assign flash_rst_n = 1'b1;
  assign mem_we_n    = 1'b1;
  assign mem_oe_n    = 1'b1;

  AST_LED_WITH_SCAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((WALK_DIV % SCAN_DIV) == 0 && walk_step) |-> scan_step); // R10

endmodule

// File: tb/hexview_top_tb.sv
module hexview_top_tb;

  localparam int SD = 8;
  localparam int WD = 32;
  localparam int NV = 6;
  // {switch byte, expected complement}
  localparam logic [15:0] VEC [NV] = '{16'h00FF, 16'hFF00, 16'hA55A,
                                       16'h3CC3, 16'h817E, 16'h7E81};

  logic clk = 0, rst_n = 0;
  logic [7:0] sw = 8'h00;
  logic [7:0] led, seg_n;
  logic [3:0] an_n;
  logic ram_ce_n, flash_ce_n, flash_rst_n, mem_we_n, mem_oe_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hexview_top #(.SCAN_DIV(SD), .WALK_DIV(WD)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw(sw), .led(led), .an_n(an_n), .seg_n(seg_n),
    .ram_ce_n(ram_ce_n), .flash_ce_n(flash_ce_n), .flash_rst_n(flash_rst_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n));

  function automatic logic [7:0] glyph(input logic [3:0] n);
    logic [6:0] p;
    case (n)
      0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F;
      4: p = 7'h66; 5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07;
      8: p = 7'h7F; 9: p = 7'h6F; 10: p = 7'h77; 11: p = 7'h7C;
      12: p = 7'h39; 13: p = 7'h5E; 14: p = 7'h79; default: p = 7'h71;
    endcase
    return {1'b1, ~p};
  endfunction

  function automatic int sel_idx(input logic [3:0] a);
    for (int i = 0; i < 4; i++) if (a == ~(4'b1 << i)) return i;
    return -1;
  endfunction

  function automatic logic [3:0] exp_nib(input logic [7:0] s, input int d);
    case (d)
      3: return s[7:4];
      2: return s[3:0];
      1: return ~s[7:4];
      default: return ~s[3:0];
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_display(input string req);
    int d = sel_idx(an_n);
    chk(d >= 0, "R2", 32'(an_n), 32'hE);
    if (d >= 0) begin
      chk(seg_n == glyph(exp_nib(sw, d)), req, 32'(seg_n), 32'(glyph(exp_nib(sw, d))));
      chk(seg_n[7] == 1'b1, "R4", 32'(seg_n[7]), 32'h1);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] pa;
    logic [7:0] pl;
    int last_scan, last_led, cyc, nled;
    // R8: state while reset is held
    #21;
    chk(led == 8'h01, "R8", 32'(led), 32'h01);
    chk(an_n == 4'b1110, "R8", 32'(an_n), 32'hE);
    chk({ram_ce_n, flash_ce_n, flash_rst_n, mem_we_n, mem_oe_n} == 5'h1F, "R1",
        32'({ram_ce_n, flash_ce_n, flash_rst_n, mem_we_n, mem_oe_n}), 32'h1F);
    @(negedge clk); rst_n = 1;

    // Vector table: each switch byte viewed on all four digits
    for (int v = 0; v < NV; v++) begin
      @(negedge clk); sw = VEC[v][15:8];
      chk((~sw) == VEC[v][7:0], "R5", 32'(~sw), 32'(VEC[v][7:0]));
      for (int k = 0; k < 4; k++) begin
        #1 chk_display("R3/R5");
        repeat (SD) @(negedge clk);
      end
    end

    // R9: mid-period switch change shows at once
    repeat (3) @(negedge clk);
    sw = 8'h5C; #1 chk_display("R9");
    sw = 8'hE2; #1 chk_display("R9");

    // R6/R7/R10: step periods, order, wrap and coincidence
    pa = an_n; pl = led; last_scan = -1; last_led = -1; cyc = 0; nled = 0;
    while (nled < 10) begin
      @(negedge clk); cyc++;
      if (an_n != pa) begin
        if (last_scan >= 0)
          chk(cyc - last_scan == SD, "R6 period", 32'(cyc - last_scan), 32'(SD));
        chk(sel_idx(an_n) == ((sel_idx(pa) + 1) % 4), "R6 order",
            32'(sel_idx(an_n)), 32'((sel_idx(pa) + 1) % 4));
        last_scan = cyc;
      end
      if (led != pl) begin
        if (last_led >= 0)
          chk(cyc - last_led == WD, "R7 period", 32'(cyc - last_led), 32'(WD));
        chk(led == {pl[6:0], pl[7]}, "R7 shift/wrap", 32'(led), 32'({pl[6:0], pl[7]}));
        chk(an_n != pa, "R10", 32'(an_n), 32'(~pa));
        last_led = cyc; nled++;
      end
      pa = an_n; pl = led;
    end
    chk($countones(led) == 1, "R7", 32'(led), 32'h1);

    // R8: asynchronous reset mid-run
    repeat (5) @(negedge clk);
    #2 rst_n = 0; #1;
    chk(led == 8'h01, "R8", 32'(led), 32'h01);
    chk(an_n == 4'b1110, "R8", 32'(an_n), 32'hE);
    #1 chk_display("R5");
    chk(mem_oe_n && mem_we_n && ram_ce_n, "R1", 32'({mem_oe_n, mem_we_n, ram_ce_n}), 32'h7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule